// File: doc/BRIEF.md
# Extended Prioritized Interrupt Controller

This block sits beside an 8051-style core and adds seven external interrupt sources to the two external interrupts the core already has. The core's original interrupt logic is untouched. In source order, the added sources are:

- 0: FSK receive
- 1: caller-ID alert
- 2: FSK transmit
- 3: line polarity reversal
- 4: off-hook
- 5: clock gating
- 6: watchdog

Each source sets a pending bit on a rising edge of its request line. Software controls the sources through three special-function registers: a pending register, an enable mask and a priority register.

Once per machine cycle the controller looks at the enabled pending sources and picks one. It then sends the core a one-cycle request together with the 16-bit entry address of that source's service routine. Two in-service flags, one per priority level, block nesting. A high-priority source may interrupt a low-priority routine, but nothing interrupts a high-priority routine. When the core reports a return-from-interrupt, the flag of the highest active level is dropped.

Top module: `xirq_ctrl`

## Requirements
- R1: After synchronous reset, the pending, mask and priority registers read 0, `irq_req` is 0, `irq_vec` is 0 and both in-service levels are clear.
- R2: A 0-to-1 change on `src_req[i]` sets pending bit i at that clock edge. A request held high sets the bit only once.
- R3: A write to the pending register at address 0xC1 clears each bit written as 0 and leaves each bit written as 1 unchanged. A rising edge in the same cycle keeps its bit set.
- R4: The mask register (0xC2) and priority register (0xC3) are written and read at their addresses, bits 6..0 for sources 6..0, and bit 7 reads 0. Writes to any other address change nothing, and reads from any other address return 0.
- R5: Selection happens only at a clock edge where `mc_tick` is 1. An accepted interrupt drives `irq_req` high for the single following cycle.
- R6: The vector for source i is 0x002B + 8*i, giving the range 0x002B to 0x005B. `irq_vec` holds its last value between requests.
- R7: A source is a candidate only if it is pending and its mask bit is 1. High priority (priority bit 1) beats low priority, and within one level the lowest index wins.
- R8: Acceptance clears the winner's pending bit and sets the in-service flag of the winner's level.
- R9: While the high level is in service, nothing is accepted. While only the low level is in service, only high-priority sources are accepted.
- R10: A pulse on `reti` clears the high in-service flag if it is set, and otherwise clears the low flag.
- R11: A masked source stays pending and is accepted once its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| src_req | input | 7 | Request lines of the seven added sources |
| reti | input | 1 | Core executed return-from-interrupt |
| sfr_addr | input | 8 | Special-function register address |
| sfr_we | input | 1 | Register write enable |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, from current address |
| irq_req | output | 1 | One-cycle vectored request to the core |
| irq_vec | output | 16 | Entry address of the accepted source |

## Verification
The bench goes after four classes of corner case.

- **Pending-bit collisions.** A software clear arrives on the same edge as a new request edge, or an acceptance collides with a fresh edge on the winning source. A design that ordered these updates wrongly would lose a request.
- **Level blocking.** A high source arrives during a low routine, and a second high arrives during a high routine. A controller with a single in-service flag would refuse the legal preemption, and one with no flags would nest without limit.
- **Return handling.** The bench sends a return with both levels active. A design that cleared both flags would let a second low source in too early.
- **Arbitration and masking.** The bench checks the lowest-index tie-break, the exact vector per source, and that masked sources are retained. A wrong arbiter shows up as a wrong vector, and a mask applied at the pending latch would silently drop requests.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned XIRQ_SRC_N = 7;
  localparam int unsigned XIRQ_DW    = 8;

  // in-service state for the two priority levels
  typedef struct packed {
    logic hi;
    logic lo;
  } xirq_lvl_t;
endpackage

// File: rtl/xirq_pend.sv
module xirq_pend #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_keep,
  input  logic [N-1:0] taken,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;
  logic [N-1:0] keep;

  assign rise = req & ~req_q;
  assign keep = sw_wr ? sw_keep : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      // a new edge always survives a same-cycle clear
      pend  <= (pend & keep & ~taken) | rise;
    end
  end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
  parameter int unsigned N  = 7,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [N-1:0]  prio,
  input  logic          busy_hi,
  input  logic          busy_lo,
  output logic          win_ok,
  output logic          win_hi,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0] grp_hi;
  logic [N-1:0] grp_lo;
  logic [N-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_split
    assign grp_hi[g] = cand[g] &  prio[g];
    assign grp_lo[g] = cand[g] & ~prio[g];
  end

  always_comb begin
    win_hi = 1'b0;
    sel    = '0;
    if (!busy_hi && (|grp_hi)) begin
      sel    = grp_hi;
      win_hi = 1'b1;
    end else if (!busy_hi && !busy_lo) begin
      sel = grp_lo;
    end
  end

  assign win_oh = sel & (~sel + {{(N-1){1'b0}}, 1'b1});
  assign win_ok = |sel;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/xirq_lvl.sv
module xirq_lvl (
  input  logic clk,
  input  logic rst,
  input  logic reti,
  input  logic acc,
  input  logic acc_hi,
  output logic isr_hi,
  output logic isr_lo
);
  logic drop_hi;
  logic drop_lo;

  assign drop_hi = reti & isr_hi;
  assign drop_lo = reti & ~isr_hi & isr_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else begin
      isr_hi <= (isr_hi & ~drop_hi) | (acc &  acc_hi);
      isr_lo <= (isr_lo & ~drop_lo) | (acc & ~acc_hi);
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int unsigned N         = xirq_pkg::XIRQ_SRC_N,
  parameter logic [15:0] VEC_BASE  = 16'h002B,
  parameter logic [15:0] VEC_STEP  = 16'h0008,
  parameter logic [7:0]  ADDR_PEND = 8'hC1,
  parameter logic [7:0]  ADDR_MASK = 8'hC2,
  parameter logic [7:0]  ADDR_PRIO = 8'hC3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mc_tick,
  input  logic [6:0]   src_req,
  input  logic         reti,
  input  logic [7:0]   sfr_addr,
  input  logic         sfr_we,
  input  logic [7:0]   sfr_wdata,
  output logic [7:0]   sfr_rdata,
  output logic         irq_req,
  output logic [15:0]  irq_vec
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend;
  logic [N-1:0]  mask_r;
  logic [N-1:0]  prio_r;
  logic [N-1:0]  win_oh;
  logic [N-1:0]  taken;
  logic [IW-1:0] win_idx;
  logic          win_ok;
  logic          win_hi;
  logic          acc;
  logic          isr_hi;
  logic          isr_lo;
  logic [15:0]   vec_n;
  xirq_pkg::xirq_lvl_t lvl;

  assign lvl.hi = isr_hi;
  assign lvl.lo = isr_lo;

  xirq_pend #(.N(N)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req    (src_req[N-1:0]),
    .sw_wr  (sfr_we && (sfr_addr == ADDR_PEND)),
    .sw_keep(sfr_wdata[N-1:0]),
    .taken  (taken),
    .pend   (pend)
  );

  xirq_arb #(.N(N)) u_arb (
    .cand   (pend & mask_r),
    .prio   (prio_r),
    .busy_hi(lvl.hi),
    .busy_lo(lvl.lo),
    .win_ok (win_ok),
    .win_hi (win_hi),
    .win_oh (win_oh),
    .win_idx(win_idx)
  );

  assign acc   = mc_tick & win_ok;
  assign taken = acc ? win_oh : '0;

  xirq_lvl u_lvl (
    .clk   (clk),
    .rst   (rst),
    .reti  (reti),
    .acc   (acc),
    .acc_hi(win_hi),
    .isr_hi(isr_hi),
    .isr_lo(isr_lo)
  );

  assign vec_n = VEC_BASE + VEC_STEP * {{(16-IW){1'b0}}, win_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_r  <= '0;
      prio_r  <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      if (sfr_we && sfr_addr == ADDR_MASK) mask_r <= sfr_wdata[N-1:0];
      if (sfr_we && sfr_addr == ADDR_PRIO) prio_r <= sfr_wdata[N-1:0];
      irq_req <= acc;
      if (acc) irq_vec <= vec_n;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == ADDR_PEND)      sfr_rdata[N-1:0] = pend;
    else if (sfr_addr == ADDR_MASK) sfr_rdata[N-1:0] = mask_r;
    else if (sfr_addr == ADDR_PRIO) sfr_rdata[N-1:0] = prio_r;
  end
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk #(
  parameter int unsigned N        = 7,
  parameter logic [15:0] VEC_BASE = 16'h002B,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input logic        clk,
  input logic        rst,
  input logic        mc_tick,
  input logic        reti,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        isr_hi,
  input logic        isr_lo
);
  localparam logic [15:0] VEC_TOP = VEC_BASE + VEC_STEP * 16'(N - 1);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_req);
  // R5
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(mc_tick));
  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_BASE && irq_vec <= VEC_TOP &&
                 ((irq_vec - VEC_BASE) % VEC_STEP) == 16'd0));
  // R8
  hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_hi) |-> irq_req);
  // R8
  lo_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_lo) |-> irq_req);
  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !$past(isr_hi));
  // R10
  reti_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (isr_hi && reti) |=> !isr_hi);
endmodule

bind xirq_ctrl xirq_chk #(.N(N), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
  .clk(clk), .rst(rst), .mc_tick(mc_tick), .reti(reti), .irq_req(irq_req),
  .irq_vec(irq_vec), .isr_hi(isr_hi), .isr_lo(isr_lo)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_PEND = 8'hC1;
  localparam logic [7:0] A_MASK = 8'hC2;
  localparam logic [7:0] A_PRIO = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_tick = 1'b0;
  logic [6:0] src_req = '0;
  logic reti = 1'b0;
  logic [7:0] sfr_addr = A_PEND;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic irq_req;
  logic [15:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state kept from the requirements
  logic [6:0] m_req_q, m_pend, m_mask, m_prio;
  logic m_hi, m_lo, m_irq;
  logic [15:0] m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl u_dut (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .src_req(src_req), .reti(reti),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [15:0] vec_of(int i);
    return 16'h002B + 16'(8 * i);
  endfunction

  function automatic int pick(logic [6:0] c, logic [6:0] p, logic hi, logic lo);
    if (!hi) for (int i = 0; i < 7; i++) if (c[i] && p[i]) return i;
    if (!hi && !lo) for (int i = 0; i < 7; i++) if (c[i] && !p[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (a == A_PEND) return {1'b0, m_pend};
    if (a == A_MASK) return {1'b0, m_mask};
    if (a == A_PRIO) return {1'b0, m_prio};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_req_q = '0; m_pend = '0; m_mask = '0; m_prio = '0;
    m_hi = 0; m_lo = 0; m_irq = 0; m_vec = '0;
  endtask

  task automatic model_step();
    logic [6:0] rise, keep, oh;
    int w;
    logic acc, whi, d_hi, d_lo;
    rise = src_req & ~m_req_q;
    w = pick(m_pend & m_mask, m_prio, m_hi, m_lo);
    acc = mc_tick && (w >= 0);
    whi = acc ? m_prio[w] : 1'b0;
    oh = acc ? (7'b1 << w) : 7'b0;
    keep = (sfr_we && sfr_addr == A_PEND) ? sfr_wdata[6:0] : 7'h7F;
    d_hi = reti && m_hi;
    d_lo = reti && !m_hi && m_lo;
    if (sfr_we && sfr_addr == A_MASK) m_mask = sfr_wdata[6:0];
    if (sfr_we && sfr_addr == A_PRIO) m_prio = sfr_wdata[6:0];
    m_pend = (m_pend & keep & ~oh) | rise;
    m_hi = (m_hi && !d_hi) || (acc && whi);
    m_lo = (m_lo && !d_lo) || (acc && !whi);
    m_irq = acc;
    if (acc) m_vec = vec_of(w);
    m_req_q = src_req;
  endtask

  // one clock: model, edge, then compare away from the edge
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " irq_req"}, 16'(irq_req), 16'(m_irq));
    if (m_irq) chk({tag, " irq_vec"}, irq_vec, m_vec);
    chk({tag, " rdata"}, 16'(sfr_rdata), 16'(m_read(sfr_addr)));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    step(tag);
    sfr_we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    sfr_addr = a;
    #1;
    chk(tag, 16'(sfr_rdata), 16'(e));
  endtask

  task automatic tick(string tag);
    mc_tick = 1; step(tag); mc_tick = 0;
  endtask

  task automatic ret(string tag);
    reti = 1; step(tag); reti = 0;
  endtask

  task automatic edge_on(int i, string tag);
    src_req[i] = 1; step(tag); src_req[i] = 0; step(tag);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    // R1 reset values
    rd(A_PEND, 8'h00, "R1 pend");
    rd(A_MASK, 8'h00, "R1 mask");
    rd(A_PRIO, 8'h00, "R1 prio");
    chk("R1 irq_req", 16'(irq_req), 16'h0);
    chk("R1 irq_vec", irq_vec, 16'h0);

    // R4 register access, bit 7 reads 0, foreign address ignored
    wr(A_MASK, 8'hFF, "R4 mask wr");
    rd(A_MASK, 8'h7F, "R4 mask bit7");
    wr(A_PRIO, 8'hD5, "R4 prio wr");
    rd(A_PRIO, 8'h55, "R4 prio rd");
    wr(8'h80, 8'h00, "R4 foreign wr");
    rd(A_MASK, 8'h7F, "R4 mask kept");
    rd(8'h80, 8'h00, "R4 foreign rd");
    wr(A_PRIO, 8'h00, "R4 prio clr");

    // R2 edge sets once; R3 software clear
    sfr_addr = A_PEND;
    src_req[3] = 1; step("R2 edge");
    rd(A_PEND, 8'h08, "R2 pend set");
    wr(A_PEND, 8'h00, "R3 clear");
    step("R2 hold"); step("R2 hold");
    rd(A_PEND, 8'h00, "R2 no reset while held");
    src_req[3] = 0; step("R2 drop");
    wr(A_PEND, 8'hFF, "R3 write one");
    rd(A_PEND, 8'h00, "R3 one no set");
    // R3 edge beats same-cycle clear
    src_req[1] = 1;
    wr(A_PEND, 8'h00, "R3 edge vs clear");
    src_req[1] = 0;
    rd(A_PEND, 8'h02, "R3 edge kept");

    // R5 no selection without tick, R6 vector, R8 pending cleared
    step("R5 no tick");
    chk("R5 idle", 16'(irq_req), 16'h0);
    tick("R5 accept");
    chk("R6 vec src1", irq_vec, 16'h0033);
    rd(A_PEND, 8'h00, "R8 pend cleared");
    ret("R10 ret lo");

    // R7 high beats low, then lowest index
    wr(A_PRIO, 8'h40, "R7 prio");
    edge_on(4, "R7 src4"); edge_on(6, "R7 src6"); edge_on(2, "R7 src2");
    tick("R7 hi first");
    chk("R7 vec src6", irq_vec, 16'h005B);
    ret("R10 ret hi");
    tick("R7 low idx");
    chk("R7 vec src2", irq_vec, 16'h003B);

    // R9 low in service: low blocked, high preempts, second high blocked
    tick("R9 low blocked");
    chk("R9 low blocked", 16'(irq_req), 16'h0);
    wr(A_PRIO, 8'h49, "R9 prio");
    edge_on(0, "R9 src0");
    tick("R9 preempt");
    chk("R9 vec src0", irq_vec, 16'h002B);
    edge_on(3, "R9 src3");
    tick("R9 hi blocked");
    chk("R9 hi blocked", 16'(irq_req), 16'h0);
    ret("R10 drop hi only");
    tick("R10 hi again");
    chk("R10 vec src3", irq_vec, 16'h0043);
    ret("R10 r1"); ret("R10 r2");

    // R11 masked source retained
    wr(A_MASK, 8'h6F, "R11 mask4 off");
    tick("R11 src4 masked");
    chk("R11 masked", 16'(irq_req), 16'h0);
    rd(A_PEND, 8'h10, "R11 still pending");
    wr(A_MASK, 8'h7F, "R11 unmask");
    tick("R11 unmasked");
    chk("R11 vec src4", irq_vec, 16'h004B);
    ret("R11 ret");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 7; b++) if ($urandom % 6 == 0) src_req[b] = ~src_req[b];
      mc_tick = ($urandom % 3 == 0);
      reti = ($urandom % 7 == 0);
      sfr_we = ($urandom % 9 == 0);
      case ($urandom % 4)
        0: sfr_addr = A_PEND;
        1: sfr_addr = A_MASK;
        2: sfr_addr = A_PRIO;
        default: sfr_addr = 8'h80;
      endcase
      sfr_wdata = 8'($urandom);
      if (sfr_we && sfr_addr == A_MASK) sfr_wdata[6:4] = 3'b111;
      step("R7/R9 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule